// File: doc/BRIEF.md
# Dual-Channel Stepped Attenuator Gain Controller

This block holds the gain setting for two independent channels of a stepped attenuator. Each channel keeps a 6-bit attenuation code. One code step is 0.5 dB. Code 0 is the highest gain and code 63 is the lowest, which gives a 31.5 dB span. The analog attenuator and amplifier sit outside the block and take the held code as their control word.

A shared two-bit mode input chooses how the codes are loaded. In bus-load mode, each channel copies its own six-bit bus while its hold input is low, and keeps its code while the hold input is high. In pulse mode, each channel has an up input and a down input. Both inputs are synchronised and their rising edges are detected, so one pulse moves the code by one step. The step size is chosen per channel and is 0.5, 1, 2 or 6 dB. Stepping saturates at both ends of the range. Rising edges on up and down in the same clock cycle return that channel to maximum gain. Each channel also has an enable input, which is registered and brought out beside the code.

Top module: `stepatt_ctrl`

## Requirements
- R1: After reset, every channel's code_o field is 0 (maximum gain) and en_o is 0. Bit n of a code field weighs 0.5·2^n dB of attenuation.
- R2: With mode_i = 2'b11 (bus-load mode) and hold_i[c] low, code field c equals par_code_i field c sampled on the previous clock edge.
- R3: In bus-load mode, while hold_i[c] is high, code field c does not change, whatever par_code_i does.
- R4: With mode_i = 2'b01 (pulse mode), a rising edge on up_i[c] lowers the code (raises gain) by one step, and a rising edge on dn_i[c] raises the code by one step. An input first sampled high on clock edge k moves the code on edge k+2.
- R5: The step size comes from the 2-bit field c of step_sel_i: 00 gives 1 code (0.5 dB), 01 gives 2, 10 gives 4 and 11 gives 12 (6 dB).
- R6: Stepping saturates. A step up that would go below code 0 gives 0, and a step down that would go above 63 gives 63.
- R7: Rising edges on up_i[c] and dn_i[c] detected in the same cycle in pulse mode set code field c to 0.
- R8: Mode values 2'b00 and 2'b10 leave every code unchanged. In pulse mode the par_code_i and hold_i inputs have no effect. In bus-load mode the pulse inputs have no effect.
- R9: en_o[c] equals en_i[c] delayed by one clock. The two channels' codes and enables never affect each other.
- R10: A pulse held high for several cycles causes exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Load mode: 11 bus-load, 01 pulse, others hold |
| en_i | input | NCH | Per-channel enable request, 1 = enabled |
| par_code_i | input | NCH*CODE_W | Bus-load code, field c at bits [c*CODE_W +: CODE_W] |
| hold_i | input | NCH | Per-channel hold: 0 = transparent, 1 = keep |
| up_i | input | NCH | Per-channel gain-up pulse (asynchronous) |
| dn_i | input | NCH | Per-channel gain-down pulse (asynchronous) |
| step_sel_i | input | 2*NCH | Per-channel step size select, field c at bits [2c +: 2] |
| code_o | output | NCH*CODE_W | Held attenuation codes |
| en_o | output | NCH | Registered per-channel enable |

## Verification
Two pulse-mode functions can act in the same cycle: the single step taken on an up or down edge, and the return to maximum gain taken when both edges land together. The bench provokes the collision by raising up_i and dn_i on the same falling edge, so that both edges reach the detector in the same cycle. It also raises them a cycle apart, which must produce two ordinary steps and no return to zero. A behavioural queue-based model predicts the code on every clock and judges each case.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD_A = 2'b00,
      MODE_PULSE  = 2'b01,
      MODE_HOLD_B = 2'b10,
      MODE_BUS    = 2'b11
   } mode_e;

   localparam int unsigned SEL_W = 2;

   // code increment for each step-size select value
   function automatic int unsigned step_incr(input logic [SEL_W-1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/stepatt_sync_edge.sv
module stepatt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("stepatt_sync_edge: STAGES must be at least 2");
   end

   // STAGES synchroniser flops plus one history flop for edge detection
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], d_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R10

endmodule

// File: rtl/stepatt_chan.sv
module stepatt_chan
   import stepatt_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [CODE_W-1:0] par_code_i,
   input  logic              hold_i,
   input  logic              up_rise_i,
   input  logic              dn_rise_i,
   input  logic [SEL_W-1:0]  step_sel_i,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   if (CODE_W < 4) begin : g_bad_width
      $error("stepatt_chan: CODE_W must hold the 6 dB increment");
   end

   mode_e             mode;
   logic [CODE_W-1:0] inc;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] code_d;
   logic [CODE_W-1:0] headroom;

   assign mode     = mode_e'(mode_i);
   assign inc      = CODE_W'(step_incr(step_sel_i));
   assign headroom = CODE_MAX - code_q;

   always_comb begin
      code_d = code_q;
      case (mode)
         MODE_BUS: begin
            if (!hold_i) code_d = par_code_i;
         end
         MODE_PULSE: begin
            if (up_rise_i && dn_rise_i) begin
               code_d = '0;
            end else if (up_rise_i) begin
               code_d = (code_q < inc) ? '0 : code_q - inc;
            end else if (dn_rise_i) begin
               code_d = (headroom < inc) ? CODE_MAX : code_q + inc;
            end
         end
         default: code_d = code_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
   end

   assign code_o = code_q;

   AST_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11 && !hold_i) |=> code_o == $past(par_code_i)); // R2
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11 && hold_i) |=> $stable(code_o)); // R3
   AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 && up_rise_i && !dn_rise_i) |=> code_o <= $past(code_o)); // R6
   AST_DN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 && dn_rise_i && !up_rise_i) |=> code_o >= $past(code_o)); // R6
   AST_BOTH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 && up_rise_i && dn_rise_i) |=> code_o == '0); // R7
   AST_IDLE_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 || mode_i == 2'b10) |=> $stable(code_o)); // R8
   AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 && !up_rise_i && !dn_rise_i) |=> $stable(code_o)); // R8

endmodule

// File: rtl/stepatt_ctrl.sv
module stepatt_ctrl
   import stepatt_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int CODE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_i,
   input  logic [NCH-1:0]        en_i,
   input  logic [NCH*CODE_W-1:0] par_code_i,
   input  logic [NCH-1:0]        hold_i,
   input  logic [NCH-1:0]        up_i,
   input  logic [NCH-1:0]        dn_i,
   input  logic [NCH*SEL_W-1:0]  step_sel_i,
   output logic [NCH*CODE_W-1:0] code_o,
   output logic [NCH-1:0]        en_o
);

   if (NCH < 1) begin : g_bad_nch
      $error("stepatt_ctrl: NCH must be at least 1");
   end

   logic [NCH-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_i;
   end

   assign en_o = en_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic up_rise;
      logic dn_rise;

      stepatt_sync_edge #(.STAGES(SYNC_STAGES)) u_up_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (up_i[c]),
         .rise_o (up_rise)
      );

      stepatt_sync_edge #(.STAGES(SYNC_STAGES)) u_dn_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (dn_i[c]),
         .rise_o (dn_rise)
      );

      stepatt_chan #(.CODE_W(CODE_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .mode_i     (mode_i),
         .par_code_i (par_code_i[c*CODE_W +: CODE_W]),
         .hold_i     (hold_i[c]),
         .up_rise_i  (up_rise),
         .dn_rise_i  (dn_rise),
         .step_sel_i (step_sel_i[c*SEL_W +: SEL_W]),
         .code_o     (code_o[c*CODE_W +: CODE_W])
      );
   end

   AST_EN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> en_o == $past(en_i)); // R9

endmodule

// File: tb/stepatt_ctrl_tb.sv
module stepatt_ctrl_tb;

   localparam int NCH = 2;
   localparam int CW  = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode_i = 2'b11;
   logic [NCH-1:0]    en_i = '0;
   logic [NCH*CW-1:0] par_code_i = '0;
   logic [NCH-1:0]    hold_i = '0;
   logic [NCH-1:0]    up_i = '0;
   logic [NCH-1:0]    dn_i = '0;
   logic [NCH*2-1:0]  step_sel_i = '0;
   logic [NCH*CW-1:0] code_o;
   logic [NCH-1:0]    en_o;

   int total = 0;
   int bad = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   stepatt_ctrl #(.NCH(NCH), .CODE_W(CW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(en_i),
      .par_code_i(par_code_i), .hold_i(hold_i), .up_i(up_i), .dn_i(dn_i),
      .step_sel_i(step_sel_i), .code_o(code_o), .en_o(en_o)
   );

   // behavioural reference: input history queues, newest sample at index 0
   bit upq[NCH][$];
   bit dnq[NCH][$];
   int mcode[NCH];
   int men[NCH];

   initial begin
      for (int c = 0; c < NCH; c++) begin
         upq[c] = '{0, 0, 0};
         dnq[c] = '{0, 0, 0};
         mcode[c] = 0;
         men[c] = 0;
      end
   end

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n) begin
            mcode[c] = 0;
            men[c] = 0;
            upq[c] = '{0, 0, 0};
            dnq[c] = '{0, 0, 0};
         end else begin
            bit ru, rd;
            int stp;
            ru = upq[c][1] && !upq[c][2];
            rd = dnq[c][1] && !dnq[c][2];
            case (step_sel_i[c*2 +: 2])
               2'b00: stp = 1;
               2'b01: stp = 2;
               2'b10: stp = 4;
               default: stp = 12;
            endcase
            if (mode_i == 2'b11) begin
               if (!hold_i[c]) mcode[c] = int'(par_code_i[c*CW +: CW]);
            end else if (mode_i == 2'b01) begin
               if (ru && rd) mcode[c] = 0;
               else if (ru) mcode[c] = (mcode[c] - stp < 0) ? 0 : mcode[c] - stp;
               else if (rd) mcode[c] = (mcode[c] + stp > 63) ? 63 : mcode[c] + stp;
            end
            men[c] = int'(en_i[c]);
            upq[c].push_front(up_i[c]);
            void'(upq[c].pop_back());
            dnq[c].push_front(dn_i[c]);
            void'(dnq[c].pop_back());
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            check(tag, $sformatf("model code ch%0d", c), int'(code_o[c*CW +: CW]), mcode[c]);
            check("R9", $sformatf("model en ch%0d", c), int'(en_o[c]), men[c]);
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_code(input string req, input int c, input int exp);
      check(req, $sformatf("code ch%0d", c), int'(code_o[c*CW +: CW]), exp);
   endtask

   task automatic pulse(input int c, input bit u, input bit d, input int len);
      @(negedge clk);
      up_i[c] = u;
      dn_i[c] = d;
      wait_n(len);
      up_i[c] = 1'b0;
      dn_i[c] = 1'b0;
      wait_n(4);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_n(4);
      // R1 reset state
      check("R1", "code ch0 in reset", int'(code_o[0 +: CW]), 0);
      check("R1", "en_o in reset", int'(en_o), 0);
      rst_n = 1'b1;
      wait_n(1);
      expect_code("R1", 0, 0);
      expect_code("R1", 1, 0);

      // R2 bus-load, R9 enable
      tag = "R2";
      mode_i = 2'b11;
      en_i = 2'b01;
      par_code_i = {6'd7, 6'd42};
      wait_n(1);
      expect_code("R2", 0, 42);
      expect_code("R2", 1, 7);
      check("R9", "en_o after one clock", int'(en_o), 1);
      en_i = 2'b10;
      wait_n(1);
      check("R9", "en_o swap", int'(en_o), 2);

      // R3 hold
      tag = "R3";
      hold_i = 2'b11;
      par_code_i = {6'd60, 6'd5};
      wait_n(3);
      expect_code("R3", 0, 42);
      expect_code("R3", 1, 7);
      hold_i = 2'b01;
      wait_n(2);
      expect_code("R9", 1, 60);
      expect_code("R3", 0, 42);
      // R8 pulses ignored in bus-load mode
      tag = "R8";
      pulse(0, 1, 0, 2);
      expect_code("R8", 0, 42);

      // R4, R5, R10 pulse mode stepping
      tag = "R4";
      mode_i = 2'b01;
      hold_i = 2'b00;
      par_code_i = '0;
      step_sel_i = {2'b00, 2'b00};
      pulse(0, 1, 0, 5);
      expect_code("R10", 0, 41);
      expect_code("R8", 1, 60);
      tag = "R5";
      step_sel_i[1:0] = 2'b01;
      pulse(0, 0, 1, 1);
      expect_code("R5", 0, 43);
      step_sel_i[1:0] = 2'b10;
      pulse(0, 0, 1, 3);
      expect_code("R5", 0, 47);
      step_sel_i[1:0] = 2'b11;
      pulse(0, 0, 1, 2);
      expect_code("R5", 0, 59);

      // R6 saturation at both ends
      tag = "R6";
      pulse(0, 0, 1, 2);
      expect_code("R6", 0, 63);
      for (int i = 0; i < 5; i++) pulse(0, 1, 0, 2);
      expect_code("R6", 0, 3);
      pulse(0, 1, 0, 2);
      expect_code("R6", 0, 0);
      pulse(0, 1, 0, 2);
      expect_code("R6", 0, 0);

      // R7 simultaneous up/down returns to maximum gain
      tag = "R7";
      step_sel_i[3:2] = 2'b00;
      pulse(1, 1, 1, 2);
      expect_code("R7", 1, 0);
      step_sel_i[1:0] = 2'b10;
      pulse(0, 0, 1, 2);
      pulse(0, 0, 1, 2);
      expect_code("R7", 0, 8);
      // edges one cycle apart: two ordinary steps
      @(negedge clk);
      dn_i[0] = 1'b1;
      @(negedge clk);
      up_i[0] = 1'b1;
      wait_n(2);
      up_i[0] = 1'b0;
      dn_i[0] = 1'b0;
      wait_n(4);
      expect_code("R7", 0, 8);
      pulse(0, 1, 1, 3);
      expect_code("R7", 0, 0);

      // R8 idle modes
      tag = "R8";
      pulse(0, 0, 1, 2);
      mode_i = 2'b00;
      par_code_i = {6'd11, 6'd22};
      pulse(0, 0, 1, 2);
      pulse(1, 1, 0, 2);
      expect_code("R8", 0, 4);
      mode_i = 2'b10;
      pulse(0, 1, 1, 2);
      expect_code("R8", 0, 4);
      expect_code("R8", 1, 0);

      // mixed stimulus judged by the model every clock
      tag = "R4";
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (i % 150 == 0) mode_i = ($urandom % 4 == 0) ? 2'b11 : 2'b01;
         up_i = NCH'($urandom);
         dn_i = NCH'($urandom);
         hold_i = NCH'($urandom);
         en_i = NCH'($urandom);
         step_sel_i = (2*NCH)'($urandom);
         par_code_i = (NCH*CW)'($urandom);
      end
      wait_n(4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule